// File: doc/BRIEF.md
# Long-Latency Pattern Detector

This block observes the link latency of every access that one core makes to a banked shared cache. It flags phases in which recent accesses have been sustained at long latency. Each access arrives as a one-cycle valid strobe together with a latency value, counted in hops or cycles. Three running statistics are kept:

- a short-memory weighted average of latency;
- an average over fixed windows of accesses;
- the largest latency seen since reset.

The flag rises when the weighted average climbs strictly above the midpoint between the window average and the maximum. A replacement policy can use the flag to protect blocks fetched from distant banks.

The weighting factor is 2^-K_SHIFT, so each update needs only a subtract and shifts. The weighted average keeps FRAC_W fractional bits. The window holds 2^WIN_LOG accesses, so the division is also a shift. Reset clears all state. Apart from reset, the block runs without interruption.

Top module: `lat_trend_detector`

## Requirements
- R1: While rst_i is high and on the first cycle after it falls, long_lat_o is 0. The weighted average, maximum, window average, window sum and access count all start from zero.
- R2: On each clock edge with valid_i high, the weighted average E, held as latency times 2^FRAC_W, becomes E - floor(E / 2^K_SHIFT) + lat_i * 2^(FRAC_W-K_SHIFT). Without valid_i, E keeps its value.
- R3: The maximum takes lat_i on a valid access when lat_i is larger than the current maximum. Otherwise the maximum keeps its value.
- R4: Valid accesses are summed. When the access count reaches 2^WIN_LOG, including the current access, the window average becomes floor(sum / 2^WIN_LOG). At the same point the sum and the count restart from zero. Between window ends the window average holds, and before the first window ends it is 0.
- R5: The threshold, in the same fixed-point scale as E, is (window average + maximum) * 2^(FRAC_W-1). The flag is computed as E strictly greater than the threshold, so equality gives 0.
- R6: The flag is re-evaluated on the clock edge that follows a valid access. It uses the statistics that access produced. At every other edge the flag holds.
- R7: A burst of far-bank accesses that follows a long run of near-bank accesses drives the flag to 1. A steady round-robin across near and far banks leaves the flag at 0.
- R8: When valid_i is low, the value on lat_i has no effect on any statistic or on the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | One access completed this cycle |
| lat_i | input | LAT_W | Link latency of that access |
| long_lat_o | output | 1 | Registered long-dynamic-latency flag |

## Verification
The in-line assertions check the following on every cycle:

- the weighted average and the maximum never move without an access;
- the maximum always covers the latest latency;
- the window average never exceeds the maximum;
- the weighted average stays within the maximum;
- the flag changes only one edge after an access.

The exact flag value needs the bench's reference model, compared on every clock:

- the averaging arithmetic;
- the point where each window closes;
- the strict comparison at equality;
- the opposite outcomes of far-bank bursts and round-robin traffic.

// File: rtl/lat_trend_detector.sv
module lat_trend_detector #(
  parameter int LAT_W   = 6,
  parameter int K_SHIFT = 2,
  parameter int FRAC_W  = 4,
  parameter int WIN_LOG = 3
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             valid_i,
  input  logic [LAT_W-1:0] lat_i,
  output logic             long_lat_o
);
  localparam int EW = LAT_W + FRAC_W;
  localparam int SW = LAT_W + WIN_LOG;

  logic [EW-1:0]      ewma_q, ewma_d, thr_fx;
  logic [LAT_W-1:0]   max_q, avg_q;
  logic [SW-1:0]      sum_q, sum_d;
  logic [WIN_LOG-1:0] cnt_q;
  logic [LAT_W:0]     mid_sum;
  logic               upd_q;

  assign ewma_d  = ewma_q - (ewma_q >> K_SHIFT) + (EW'(lat_i) << (FRAC_W - K_SHIFT));
  assign sum_d   = sum_q + SW'(lat_i);
  assign mid_sum = {1'b0, avg_q} + {1'b0, max_q};
  assign thr_fx  = EW'(mid_sum) << (FRAC_W - 1);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ewma_q     <= '0;
      max_q      <= '0;
      avg_q      <= '0;
      sum_q      <= '0;
      cnt_q      <= '0;
      upd_q      <= 1'b0;
      long_lat_o <= 1'b0;
    end else begin
      upd_q <= valid_i;
      if (upd_q) long_lat_o <= ewma_q > thr_fx;
      if (valid_i) begin
        ewma_q <= ewma_d;
        if (lat_i > max_q) max_q <= lat_i;
        cnt_q <= cnt_q + 1'b1;
        if (&cnt_q) begin
          avg_q <= LAT_W'(sum_d >> WIN_LOG);
          sum_q <= '0;
        end else begin
          sum_q <= sum_d;
        end
      end
    end
  end

  p_ewma_hold_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    !valid_i |=> $stable(ewma_q));
  p_ewma_within_max_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    ewma_q <= (EW'(max_q) << FRAC_W));
  p_max_covers_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    valid_i |=> max_q >= $past(lat_i));
  p_max_hold_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    !valid_i |=> $stable(max_q));
  p_avg_le_max_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    avg_q <= max_q);
  p_flag_hold_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(valid_i, 2) |-> $stable(long_lat_o));
endmodule

// File: tb/lat_trend_detector_tb.sv
module lat_trend_detector_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LW = 6, KS = 2, FW = 4, WL = 3;

  logic clk = 0, rst = 1, valid = 0;
  logic [LW-1:0] lat = '0;
  logic flag;
  int total = 0, bad = 0, cyc = 0;
  int e = 0, mx = 0, av = 0, sm = 0, cn = 0, mflag = 0, upd = 0;
  string tag = "R1";
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lat_trend_detector #(.LAT_W(LW), .K_SHIFT(KS), .FRAC_W(FW), .WIN_LOG(WL)) dut_i (
    .clk_i(clk), .rst_i(rst), .valid_i(valid), .lat_i(lat), .long_lat_o(flag));

  // reference model: R2 R3 R4 R5 R6 R8
  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      e = 0; mx = 0; av = 0; sm = 0; cn = 0; mflag = 0; upd = 0;
    end else begin
      if (upd != 0) mflag = (e > ((av + mx) << (FW - 1))) ? 1 : 0;
      upd = valid;
      if (valid) begin
        e = e - (e >> KS) + (int'(lat) << (FW - KS));
        if (int'(lat) > mx) mx = int'(lat);
        sm += int'(lat); cn++;
        if (cn == (1 << WL)) begin av = sm >> WL; sm = 0; cn = 0; end
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      total++;
      if (int'(flag) != mflag) begin
        bad++;
        $display("FAIL %s (R2 R4 R5 R6) cycle %0d: actual=%0d expected=%0d", tag, cyc, flag, mflag);
      end
    end
    if (cyc > 50000 && !done) begin
      done = 1; total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic acc(input int l, input int gap);
    @(negedge clk); valid = 1; lat = LW'(l);
    @(negedge clk); valid = 0; lat = LW'(63 - l);
    for (int i = 0; i < gap; i++) @(negedge clk);
  endtask

  task automatic expect_flag(input int exp, input string r);
    @(negedge clk); @(negedge clk);
    total++;
    if (int'(flag) != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", r, flag, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; valid = 0;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  initial begin
    do_reset();
    expect_flag(0, "R1");
    tag = "R2";
    for (int i = 0; i < 20; i++) acc(i % 7 + 3, i % 3);
    tag = "R5";
    for (int i = 0; i < 40; i++) acc(12, 0);
    expect_flag(0, "R5 equality");
    tag = "R8";
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); lat = LW'(63 - i);
    end
    expect_flag(0, "R8");
    tag = "R7";
    do_reset();
    for (int i = 0; i < 32; i++) acc(2, 1);
    for (int i = 0; i < 6; i++) acc(30, 0);
    expect_flag(1, "R7 burst");
    tag = "R3";
    for (int i = 0; i < 30; i++) acc(2, 0);
    expect_flag(0, "R3 decay");
    tag = "R7";
    do_reset();
    for (int r = 0; r < 20; r++) begin
      acc(1, 0); acc(10, 0); acc(20, 0); acc(30, 0);
    end
    expect_flag(0, "R7 round robin");
    tag = "R4";
    for (int i = 0; i < 16; i++) acc((i * 13) % 40 + 1, i % 2);
    expect_flag(mflag, "R4");
    tag = "R1";
    do_reset();
    expect_flag(0, "R1 after reset");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule